// File: doc/BRIEF.md
# Decimal Rotation Scale Compensator

This block multiplies one decimal coordinate by the length correction that a single decimal vectoring step needs. A step of tangent t = c·10^-d lengthens the vector by sqrt(1+t²), so the coordinate is multiplied by cos(arctan(t)). When asked, the block also applies t itself and returns t·cos(arctan(t))·X. A datapath that updates x and y therefore takes all four compensated terms of a step from four copies of this block. The factor depends on c and d and so changes from step to step. It is not applied as a single constant multiply at the end.

Each BCD digit of the coordinate reads its own small table, addressed by that digit, c, d and the term select. The table returns the exact product of the digit and the chosen factor, with eight fractional digits. The partial products are placed at the weight of their digit and summed exactly in a chain of decimal adders. The sum is then cut to six fractional digits. A valid flag travels alongside, and the result appears two clock cycles after the operands.

Top module: `dcomp_mul`

## Requirements
- R1: While rst_ni is low, vld_o is 0 and res_o is all zero.
- R2: vld_o is vld_i delayed by exactly two clock cycles, and one operand set may be accepted on every cycle.
- R3: With scale_i = 0, res_o = floor(X·F / 10^8), where F = floor(10^8 / sqrt(1 + t²)) and t = c·10^-d. Here c is mant_i, d is expo_i, and X is the coordinate. coord_i holds seven BCD digits: bits [27:24] are the units digit, and bits [3:0] are the 10^-6 digit. res_o uses the same encoding.
- R4: With scale_i = 1, res_o = floor(X·c·F / 10^(8+d)), with F as in R3.
- R5: F is exactly 10^8 when t ≤ 0.001, that is when d ≥ 4, or when d = 3 and c ≤ 1. With these operands the unscaled result equals the coordinate.
- R6: With c = 0, the unscaled result equals the coordinate and the scaled result is zero.
- R7: Every digit of res_o is a valid BCD digit (0 to 9) whenever vld_o is 1.
- R8: res_o keeps its value on every cycle where vld_o is 0.
- R9: A mant_i value from 10 to 15 gives a zero result for both terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| vld_i | input | 1 | Operands on this cycle are valid |
| coord_i | input | 28 | BCD coordinate, 1 integer and 6 fractional digits |
| mant_i | input | 4 | Tangent mantissa c |
| expo_i | input | 3 | Tangent exponent d |
| scale_i | input | 1 | 0: X·cos, 1: c·10^-d·X·cos |
| vld_o | output | 1 | Result valid |
| res_o | output | 28 | Compensated BCD result, same format as coord_i |

## Verification
The bench aims at the edge of the unity rule. There, d = 3 with c = 1 must give the coordinate unchanged, while c = 2 must give 0.999998. A design that moved the threshold would be off by one or two units in the last place. It also covers the largest right shift (d = 7 on a scaled term) and the 9.999999 coordinate with a scaled term of c = 9. A wrong alignment or a truncation taken before the sum would show there as a wrong low digit. Further cases are c = 0, out-of-range mantissas, and long idle stretches after a valid result. A design that gated the output register or the flag pipeline wrongly would leak stale or changing results in those stretches.

// File: rtl/dcomp_pkg.sv
package dcomp_pkg;
  localparam int RADIX     = 10;
  localparam int FRAC_DIG  = 6;
  localparam int INT_DIG   = 1;
  localparam int COORD_DIG = FRAC_DIG + INT_DIG;
  localparam int COORD_W   = 4 * COORD_DIG;
  localparam int MANT_W    = 4;
  localparam int EXP_W     = 3;
  localparam int MANT_MAX  = 9;
  localparam int TAB_FRAC  = 8;
  localparam int ENT_DIG   = TAB_FRAC + 2;
  localparam int ENT_W     = 4 * ENT_DIG;
  localparam int DK_MAX    = 4;                    // exponents >= this give unit factor
  localparam int N_DK      = DK_MAX + 1;
  localparam int DK_W      = $clog2(N_DK);
  localparam int N_ENT     = 2 * RADIX * N_DK * RADIX;
  localparam int IDX_W     = $clog2(N_ENT);
  localparam int ACC_DIG   = ENT_DIG + COORD_DIG;
  localparam int ACC_W     = 4 * ACC_DIG;
  localparam int MAX_SHIFT = TAB_FRAC + (1 << EXP_W) - 1;
  localparam int SH_W      = $clog2(MAX_SHIFT + 1);
  localparam int WIDE_W    = 4 * (MAX_SHIFT + COORD_DIG);

  typedef logic [ENT_W-1:0] ent_t;
  typedef ent_t [N_ENT-1:0] tab_t;
  typedef logic [79:0]      big_t;

  function automatic big_t pow10(input int n);
    big_t r = 80'd1;
    for (int i = 0; i < n; i++) r = r * 80'd10;
    return r;
  endfunction

  function automatic big_t isqrt(input big_t n);
    big_t r = '0;
    big_t t;
    for (int b = 39; b >= 0; b--) begin
      t = r | (big_t'(1) << b);
      if (t * t <= n) r = t;
    end
    return r;
  endfunction

  // floor(10^TAB_FRAC / sqrt(1 + (c*10^-dk)^2)), unity for tiny angles
  function automatic longint cos_fix(input int c, input int dk);
    big_t num, den;
    if (c == 0 || dk >= DK_MAX || (dk == DK_MAX - 1 && c <= 1))
      return longint'(pow10(TAB_FRAC));
    num = pow10(2 * TAB_FRAC + 2 * dk);
    den = pow10(2 * dk) + big_t'(c * c);
    return longint'(isqrt(num / den));
  endfunction

  function automatic ent_t to_bcd(input longint v);
    ent_t   r;
    longint x = v;
    for (int i = 0; i < ENT_DIG; i++) begin
      r[4*i +: 4] = 4'(x % RADIX);
      x = x / RADIX;
    end
    return r;
  endfunction

  function automatic tab_t build_tab();
    tab_t   t;
    longint f, g;
    int     idx;
    for (int c = 0; c < RADIX; c++) begin
      for (int dk = 0; dk < N_DK; dk++) begin
        f = cos_fix(c, dk);
        for (int s = 0; s < 2; s++) begin
          g = (s == 1) ? f * longint'(c) : f;
          for (int dg = 0; dg < RADIX; dg++) begin
            idx = ((s * RADIX + c) * N_DK + dk) * RADIX + dg;
            t[idx] = to_bcd(g * longint'(dg));
          end
        end
      end
    end
    return t;
  endfunction

  localparam tab_t PROD_TAB = build_tab();
endpackage

// File: rtl/dcomp_bcd_add.sv
module dcomp_bcd_add #(
  parameter int NDIG = 4
) (
  input  logic [4*NDIG-1:0] a_i,
  input  logic [4*NDIG-1:0] b_i,
  output logic [4*NDIG-1:0] sum_o
);
  always_comb begin
    logic       cy;
    logic [4:0] t;
    cy    = 1'b0;
    sum_o = '0;
    for (int i = 0; i < NDIG; i++) begin
      t = 5'(a_i[4*i +: 4]) + 5'(b_i[4*i +: 4]) + 5'(cy);
      if (t > 5'd9) t = t + 5'd6;
      cy = t[4];
      sum_o[4*i +: 4] = t[3:0];
    end
  end
endmodule

// File: rtl/dcomp_digit_lut.sv
module dcomp_digit_lut
  import dcomp_pkg::*;
(
  input  logic [3:0]        dig_i,
  input  logic [MANT_W-1:0] mant_i,
  input  logic [EXP_W-1:0]  expo_i,
  input  logic              scale_i,
  output ent_t              prod_o
);
  logic [DK_W-1:0]  dk;
  logic [IDX_W-1:0] idx;

  always_comb begin
    dk  = (int'(expo_i) >= DK_MAX) ? DK_W'(DK_MAX) : DK_W'(expo_i);
    idx = IDX_W'(((int'(scale_i) * RADIX + int'(mant_i)) * N_DK + int'(dk)) * RADIX
                 + int'(dig_i));
    if (int'(dig_i) >= RADIX || int'(mant_i) > MANT_MAX) prod_o = '0;
    else prod_o = PROD_TAB[idx];
  end
endmodule

// File: rtl/dcomp_pp_sum.sv
module dcomp_pp_sum
  import dcomp_pkg::*;
#(
  parameter int NPP = COORD_DIG
) (
  input  ent_t [NPP-1:0]   pp_i,
  output logic [ACC_W-1:0] acc_o
);
  logic [ACC_W-1:0] aligned [NPP];
  logic [ACC_W-1:0] psum    [NPP];

  for (genvar k = 0; k < NPP; k++) begin : g_align
    assign aligned[k] = ACC_W'(pp_i[k]) << (4 * k);
  end

  assign psum[0] = aligned[0];

  for (genvar k = 1; k < NPP; k++) begin : g_chain
    dcomp_bcd_add #(.NDIG(ACC_DIG)) u_add (
      .a_i   (psum[k-1]),
      .b_i   (aligned[k]),
      .sum_o (psum[k])
    );
  end

  assign acc_o = psum[NPP-1];
endmodule

// File: rtl/dcomp_mul.sv
module dcomp_mul
  import dcomp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               vld_i,
  input  logic [COORD_W-1:0] coord_i,
  input  logic [MANT_W-1:0]  mant_i,
  input  logic [EXP_W-1:0]   expo_i,
  input  logic               scale_i,
  output logic               vld_o,
  output logic [COORD_W-1:0] res_o
);
  ent_t [COORD_DIG-1:0] pp_d, s1_pp;
  logic                 s1_vld;
  logic [SH_W-1:0]      s1_shift;
  logic [ACC_W-1:0]     acc;
  logic [COORD_W-1:0]   res_n;

  for (genvar k = 0; k < COORD_DIG; k++) begin : g_lut
    dcomp_digit_lut u_lut (
      .dig_i   (coord_i[4*k +: 4]),
      .mant_i  (mant_i),
      .expo_i  (expo_i),
      .scale_i (scale_i),
      .prod_o  (pp_d[k])
    );
  end

  // stage 1: table outputs and final alignment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld   <= 1'b0;
      s1_pp    <= '0;
      s1_shift <= '0;
    end else begin
      s1_vld <= vld_i;
      if (vld_i) begin
        s1_pp    <= pp_d;
        s1_shift <= SH_W'(TAB_FRAC) + (scale_i ? SH_W'(expo_i) : SH_W'(0));
      end
    end
  end

  dcomp_pp_sum u_sum (
    .pp_i  (s1_pp),
    .acc_o (acc)
  );

  // exact sum, then drop table fraction plus exponent digits
  always_comb res_n = COORD_W'(WIDE_W'(acc) >> (4 * s1_shift));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      res_o <= '0;
    end else begin
      vld_o <= s1_vld;
      if (s1_vld) res_o <= res_n;
    end
  end
endmodule

// File: rtl/dcomp_mul_chk.sv
module dcomp_mul_chk
  import dcomp_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               vld_i,
  input logic [COORD_W-1:0] coord_i,
  input logic [MANT_W-1:0]  mant_i,
  input logic [EXP_W-1:0]   expo_i,
  input logic               scale_i,
  input logic               vld_o,
  input logic [COORD_W-1:0] res_o
);
  logic               v1, v2, s1, s2;
  logic [COORD_W-1:0] c1, c2;
  logic [MANT_W-1:0]  m1, m2;
  logic [EXP_W-1:0]   e1, e2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      {v1, v2, s1, s2} <= '0;
      {c1, c2, m1, m2, e1, e2} <= '0;
    end else begin
      v1 <= vld_i;   v2 <= v1;
      s1 <= scale_i; s2 <= s1;
      c1 <= coord_i; c2 <= c1;
      m1 <= mant_i;  m2 <= m1;
      e1 <= expo_i;  e2 <= e1;
    end
  end

  function automatic bit all_bcd(input logic [COORD_W-1:0] v);
    for (int i = 0; i < COORD_DIG; i++) if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == v2);

  // R7
  bcd_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> all_bcd(res_o));

  // R3
  cos_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !s2 && all_bcd(c2)) |-> res_o <= c2);

  // R4
  scaled_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && s2 && all_bcd(c2)) |-> res_o <= c2);

  // R5
  unity_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && !s2 && all_bcd(c2) && int'(m2) <= MANT_MAX &&
     (int'(e2) >= DK_MAX || (int'(e2) == DK_MAX - 1 && m2 <= 4'd1))) |-> res_o == c2);

  // R6
  zero_mant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && s2 && m2 == '0) |-> res_o == '0);

  // R9
  bad_mant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && int'(m2) > MANT_MAX) |-> res_o == '0);

  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_o |-> $stable(res_o));
endmodule

bind dcomp_mul dcomp_mul_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .vld_i   (vld_i),
  .coord_i (coord_i),
  .mant_i  (mant_i),
  .expo_i  (expo_i),
  .scale_i (scale_i),
  .vld_o   (vld_o),
  .res_o   (res_o)
);

// File: tb/sim_dcomp_mul.sv
module sim_dcomp_mul;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic        scale = 1'b0;
  logic [27:0] coord = '0;
  logic [3:0]  mant = '0;
  logic [2:0]  expo = '0;
  logic        vld_o;
  logic [27:0] res_o;
  int          tag = 3;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  dcomp_mul u0 (
    .clk_i (clk), .rst_ni (rst_n), .vld_i (vld), .coord_i (coord),
    .mant_i (mant), .expo_i (expo), .scale_i (scale),
    .vld_o (vld_o), .res_o (res_o)
  );

  function automatic string rname(input int n);
    case (n)
      1: return "R1"; 2: return "R2"; 3: return "R3";
      4: return "R4"; 5: return "R5"; 6: return "R6";
      7: return "R7"; 8: return "R8"; default: return "R9";
    endcase
  endfunction

  task automatic chk(input bit ok, input int req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", rname(req), act, exp, $time);
    end
  endtask

  function automatic longint bcd2int(input logic [27:0] v);
    longint r = 0;
    for (int i = 6; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [27:0] int2bcd(input longint v);
    logic [27:0] r;
    longint x = v;
    for (int i = 0; i < 7; i++) begin
      r[4*i +: 4] = 4'(x % 10);
      x = x / 10;
    end
    return r;
  endfunction

  // reference from R3..R6, R9
  function automatic logic [27:0] model(input logic [27:0] x, input int c, input int d, input bit s);
    real    t;
    longint f, g, div;
    if (c > 9) return '0;
    if (c == 0 || d >= 4 || (d == 3 && c <= 1)) f = 100000000;
    else begin
      t = real'(c) * (10.0 ** (-d));
      f = longint'($floor(1.0e8 / $sqrt(1.0 + t * t)));
    end
    g   = s ? f * longint'(c) : f;
    div = 100000000;
    if (s) for (int i = 0; i < d; i++) div = div * 10;
    return int2bcd((bcd2int(x) * g) / div);
  endfunction

  logic        mv1, mv2;
  logic [27:0] mr1, mres;
  int          mt1, mtag;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mv1 <= 1'b0; mv2 <= 1'b0; mr1 <= '0; mres <= '0; mt1 <= 3; mtag <= 3;
    end else begin
      mv1 <= vld;
      if (vld) begin
        mr1 <= model(coord, int'(mant), int'(expo), scale);
        mt1 <= tag;
      end
      mv2 <= mv1;
      if (mv1) begin
        mres <= mr1;
        mtag <= mt1;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(vld_o == mv2, 2, longint'(vld_o), longint'(mv2));               // R2
      chk(res_o == mres, mv2 ? mtag : 8, longint'(res_o), longint'(mres)); // R8 when idle
      if (vld_o) begin
        bit ok = 1'b1;
        for (int i = 0; i < 7; i++) if (res_o[4*i +: 4] > 4'd9) ok = 1'b0;
        chk(ok, 7, longint'(res_o), longint'(mres));                       // R7
      end
    end
  end

  function automatic logic [27:0] rand_bcd();
    logic [27:0] r;
    for (int i = 0; i < 7; i++) r[4*i +: 4] = 4'($urandom_range(0, 9));
    return r;
  endfunction

  task automatic dir(input logic [27:0] x, input int c, input int d, input bit s,
                     input logic [27:0] exp, input int req);
    @(negedge clk);
    vld = 1'b1; coord = x; mant = 4'(c); expo = 3'(d); scale = s; tag = req;
    @(negedge clk);
    vld = 1'b0;
    @(negedge clk);
    chk(res_o == exp && vld_o, req, longint'(res_o), longint'(exp));
  endtask

  task automatic finish_sim();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired, actual=running expected=done");
      finish_sim();
    end
  end

  initial begin
    repeat (3) begin
      @(negedge clk);
      chk(vld_o == 1'b0, 1, longint'(vld_o), 0);  // R1
      chk(res_o == '0, 1, longint'(res_o), 0);    // R1
    end
    rst_n = 1'b1;

    // R3 known factors
    dir(28'h1000000, 3, 1, 1'b0, 28'h0957826, 3);
    dir(28'h1000000, 1, 0, 1'b0, 28'h0707106, 3);
    // R4 scaled terms, including widest shift
    dir(28'h1000000, 1, 0, 1'b1, 28'h0707106, 4);
    dir(28'h1000000, 3, 1, 1'b1, 28'h0287347, 4);
    dir(28'h9999999, 9, 7, 1'b1, 28'h0000008, 4);
    // R5 unity threshold
    dir(28'h1000000, 1, 3, 1'b0, 28'h1000000, 5);
    dir(28'h1000000, 2, 3, 1'b0, 28'h0999998, 5);
    dir(28'h0706479, 9, 5, 1'b0, 28'h0706479, 5);
    // R6 zero mantissa
    dir(28'h0304659, 0, 2, 1'b0, 28'h0304659, 6);
    dir(28'h0304659, 0, 2, 1'b1, 28'h0000000, 6);
    // R9 out-of-range mantissa
    dir(28'h0555555, 12, 1, 1'b0, 28'h0000000, 9);
    dir(28'h0555555, 15, 0, 1'b1, 28'h0000000, 9);

    // R8 idle with changing operands
    repeat (12) begin
      @(negedge clk);
      vld = 1'b0; coord = rand_bcd(); mant = 4'($urandom_range(0, 9));
      expo = 3'($urandom_range(0, 7)); scale = 1'($urandom_range(0, 1)); tag = 8;
    end

    // R5 boundary sweep
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      vld = 1'b1; coord = rand_bcd(); mant = 4'($urandom_range(0, 3));
      expo = 3'($urandom_range(2, 4)); scale = 1'($urandom_range(0, 1));
      tag = scale ? 4 : 5;
    end

    // R3 R4 mixed traffic with gaps
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      vld   = ($urandom_range(0, 9) < 7);
      coord = rand_bcd();
      mant  = ($urandom_range(0, 19) == 0) ? 4'($urandom_range(10, 15)) : 4'($urandom_range(0, 9));
      expo  = 3'($urandom_range(0, 7));
      scale = 1'($urandom_range(0, 1));
      tag   = (mant > 4'd9) ? 9 : (mant == 4'd0) ? 6 : (scale ? 4 : 3);
    end

    @(negedge clk);
    vld = 1'b0;
    repeat (4) @(negedge clk);
    done = 1'b1;
    finish_sim();
  end
endmodule